// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for a four-beat burst into a synchronous memory. A burst begins when an address strobe is seen at a rising clock edge. Two strobes can start a burst. One comes from a processor and is honoured only while the primary chip select is high. The other comes from a cache controller and is always honoured. Each strobe has its own address bus. On a start, the block registers the upper address bits, the two-bit starting offset and the ordering mode. After that, each clock edge with the advance input high moves the burst to its next beat.

The low address bits follow one of two orderings. In interleaved order they are the starting offset XOR the beat number. In linear order they are the starting offset plus the beat number, modulo four. The beat number wraps, so a fifth step returns to the starting offset. The output address is the registered upper bits joined with the current offset. A new start replaces the current burst at any point, including partway through a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and after it is released, with no strobe seen, arrAddr is zero.
- R2: One edge after a start, arrAddr equals the full address from the winning strobe's address bus, and burstOff equals that address's two low bits.
- R3: With modeInterleave low at the start (linear order), successive advances give offsets start+1, start+2 and start+3, modulo 4. For example, a start of 1 gives 1,2,3,0.
- R4: With modeInterleave high at the start (interleaved order), beat n gives offset start XOR n. For example, a start of 1 gives 1,0,3,2.
- R5: A fourth advance after the start brings the offset back to the starting offset, in both orderings.
- R6: On an edge with advance low and no honoured strobe, arrAddr keeps its value.
- R7: A strobe that arrives partway through a burst starts a new burst from beat 0 with the new address. Advance is ignored on an edge that starts a burst.
- R8: When the processor strobe (with csPrimary high) and the controller strobe arrive on the same edge, the burst starts from procAddr.
- R9: A processor strobe on an edge with csPrimary low is ignored, so arrAddr does not change. A controller strobe is honoured whatever the level of csPrimary.
- R10: The ordering is fixed at the start of each burst. Changing modeInterleave during a burst does not change the offsets that the rest of that burst produces.
- R11: The upper address bits (arrAddr above bit 1) do not change until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeInterleave | input | 1 | 1 selects interleaved order, 0 selects linear order; taken at burst start |
| csPrimary | input | 1 | Primary chip select; qualifies the processor strobe |
| procAds | input | 1 | Processor address strobe |
| ctrlAds | input | 1 | Controller address strobe |
| advance | input | 1 | Moves the burst to its next beat |
| procAddr | input | ADDR_W | Address that goes with the processor strobe |
| ctrlAddr | input | ADDR_W | Address that goes with the controller strobe |
| arrAddr | output | ADDR_W | Array address: registered upper bits joined with the current offset |
| burstOff | output | 2 | Current burst offset |

## Verification
The assertions check four behaviours on every cycle. A step in linear order increments the offset. A step in interleaved order always toggles bit 0 of the offset. The upper bits and the offset hold when no start and no step happen. A processor start captures procAddr, and a processor strobe gated off by the chip select leaves the address unchanged. The bench scenarios cover what a one-cycle property cannot show. These are the full four-beat sequence for each start offset in both orders, the return to the start after the fourth step, a restart partway through a burst, and a mode change during a burst that leaves the remaining offsets as they were.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int OFF_W = 2;

  typedef struct packed {
    logic load;     // start a new burst this edge
    logic useProc;  // capture from the processor address bus
    logic step;     // move to the next beat
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        csPrimary,
  input  logic        procAds,
  input  logic        ctrlAds,
  input  logic        advance,
  output seqStrobes_t strb
);
  logic procHit;

  always_comb begin
    procHit      = procAds & csPrimary;
    strb.load    = procHit | ctrlAds;
    strb.useProc = procHit;
    strb.step    = advance & ~(procHit | ctrlAds);
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic              modeInterleave,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [ADDR_W-1:0] ctrlAddr,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [OFF_W-1:0]  burstOff
);
  localparam int UP_W = ADDR_W - OFF_W;

  logic [UP_W-1:0]   upperQ;
  logic [OFF_W-1:0]  startQ;
  logic [OFF_W-1:0]  beatQ;
  logic              modeQ;
  logic [ADDR_W-1:0] selAddr;
  logic [OFF_W-1:0]  offset;

  always_comb begin
    selAddr = strb.useProc ? procAddr : ctrlAddr;
    offset  = modeQ ? (startQ ^ beatQ) : (startQ + beatQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
      modeQ  <= 1'b0;
    end else if (strb.load) begin
      upperQ <= selAddr[ADDR_W-1:OFF_W];
      startQ <= selAddr[OFF_W-1:0];
      beatQ  <= '0;
      modeQ  <= modeInterleave;
    end else if (strb.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  assign burstOff = offset;
  assign arrAddr  = {upperQ, offset};

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !modeQ) |=> (burstOff == $past(burstOff) + 2'd1));

  // R4
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && modeQ) |=> (burstOff[0] != $past(burstOff[0])));

  // R11
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(upperQ));

  // R6
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(burstOff));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeInterleave,
  input  logic              csPrimary,
  input  logic              procAds,
  input  logic              ctrlAds,
  input  logic              advance,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [ADDR_W-1:0] ctrlAddr,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [1:0]        burstOff
);
  seqStrobes_t strb;

  burst_seq_ctrl ctrl_i (
    .csPrimary (csPrimary),
    .procAds   (procAds),
    .ctrlAds   (ctrlAds),
    .advance   (advance),
    .strb      (strb)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .modeInterleave (modeInterleave),
    .procAddr       (procAddr),
    .ctrlAddr       (ctrlAddr),
    .arrAddr        (arrAddr),
    .burstOff       (burstOff)
  );

  // R8
  proc_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procAds && csPrimary) |=> (arrAddr == $past(procAddr)));

  // R9
  proc_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procAds && !csPrimary && !ctrlAds && !advance) |=> $stable(arrAddr));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rstN, modeInterleave, csPrimary, procAds, ctrlAds, advance;
  logic [AW-1:0] procAddr, ctrlAddr, arrAddr;
  logic [1:0] burstOff;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .modeInterleave(modeInterleave),
    .csPrimary(csPrimary), .procAds(procAds), .ctrlAds(ctrlAds),
    .advance(advance), .procAddr(procAddr), .ctrlAddr(ctrlAddr),
    .arrAddr(arrAddr), .burstOff(burstOff)
  );

  // {mode, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2},
    {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2},
    {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    procAds = 1'b0; ctrlAds = 1'b0; advance = 1'b0;
  endtask

  initial begin
    for (int w = 0; w < 20000; w++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual expired expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-3:0] up;
    rstN = 1'b0; modeInterleave = 1'b0; csPrimary = 1'b1;
    procAddr = '0; ctrlAddr = '0;
    idle();
    @(negedge clk);
    tick(); tick();
    chk("R1 in reset", arrAddr, '0);
    rstN = 1'b1;
    tick();
    chk("R1 after reset", arrAddr, '0);

    // R2 R3 R4 R5: table walk
    for (int v = 0; v < 8; v++) begin
      up = 15'h1230 + 15'(v * 7);
      modeInterleave = VEC[v][10];
      csPrimary = 1'b1;
      procAds = 1'b1;
      procAddr = {up, VEC[v][9:8]};
      tick();
      idle();
      chk(VEC[v][10] ? "R2 R4 beat0" : "R2 R3 beat0", arrAddr, {up, VEC[v][7:6]});
      for (int b = 1; b < 4; b++) begin
        advance = 1'b1;
        tick();
        chk(VEC[v][10] ? "R4 beat" : "R3 beat", arrAddr,
            {up, VEC[v][7 - 2*b -: 2]});
      end
      tick();
      advance = 1'b0;
      chk("R5 wrap R11", arrAddr, {up, VEC[v][9:8]});
    end

    // R6: hold with advance low
    modeInterleave = 1'b0;
    procAds = 1'b1; procAddr = 17'h0AAA9;
    tick(); idle();
    advance = 1'b1; tick(); advance = 1'b0;
    tick(); tick();
    chk("R6 hold", arrAddr, 17'h0AAAA);

    // R7: restart mid burst, advance ignored on start edge
    ctrlAds = 1'b1; advance = 1'b1; ctrlAddr = 17'h15553;
    tick(); idle();
    chk("R7 restart", arrAddr, 17'h15553);
    advance = 1'b1; tick(); advance = 1'b0;
    chk("R7 first step after restart", arrAddr, 17'h15550);

    // R8: both strobes, processor wins
    procAds = 1'b1; ctrlAds = 1'b1; csPrimary = 1'b1;
    procAddr = 17'h00102; ctrlAddr = 17'h1FF01;
    tick(); idle();
    chk("R8 priority", arrAddr, 17'h00102);

    // R9: processor strobe gated by chip select
    csPrimary = 1'b0; procAds = 1'b1; procAddr = 17'h07773;
    tick(); idle();
    chk("R9 gated proc", arrAddr, 17'h00102);
    ctrlAds = 1'b1; ctrlAddr = 17'h03331;
    tick(); idle();
    chk("R9 ctrl without cs", arrAddr, 17'h03331);
    csPrimary = 1'b1;

    // R10: mode change mid burst ignored (linear start 1 -> 1,2,3,0)
    modeInterleave = 1'b0; procAds = 1'b1; procAddr = 17'h04441;
    tick(); idle();
    modeInterleave = 1'b1;
    advance = 1'b1; tick();
    chk("R10 beat1", arrAddr, 17'h04442);
    tick();
    chk("R10 beat2", arrAddr, 17'h04443);
    advance = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule